// File: doc/BRIEF.md
# Translation Fault Capture and Interrupt Unit

This block sits beside an address translation engine and records the first fault that engine reports. A fault event brings an eight-bit type vector, the virtual address that missed, the physical address involved and a 16-bit requester identifier. The unit latches the first such event into status registers that software reads over a simple 32-bit register bus. It raises an interrupt whenever a latched type bit is also enabled. While a fault is held, the unit tells the engine to send faulting traffic to a programmable, 128-byte aligned protect buffer.

Software handles a fault by reading the status, the addresses and the decoded requester. It then writes the clear bit in the interrupt control word. The clear releases the capture, drops the interrupt and ends the redirect.

The capture logic is a two-state machine. In `ST_IDLE` nothing is held; the CAPTURE transition to `ST_HELD` fires on a valid event whose type vector is nonzero. `ST_HELD` keeps the latched record. The RELEASE transition back to `ST_IDLE` fires when the clear bit is written.

Top module: `fcap_unit`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is low, `redir_o` is low, `coh_en_o` is 0 and `prot_sel_o` is 0.
- R2: Control word at byte offset 0x00: bit 8 is a read/write coherency enable driving `coh_en_o`, and bits [6:5] are a read/write protect select driving `prot_sel_o`. All other bits read 0.
- R3: Interrupt control word at offset 0x04: bits [7:0] are read/write enables. Bit order is: 0 translation fault, 1 multi-hit, 2 invalid PA, 3 entry replacement, 4 table walk, 5 TLB miss, 6 prefetch FIFO overflow, 7 miss FIFO overflow.
- R4: Bit 12 of the interrupt control word is a write-1 clear strobe. It always reads back as 0.
- R5: In `ST_IDLE`, an event with `evt_valid_i` high and a nonzero `evt_type_i` is captured. Its type vector appears at offset 0x08. Its virtual address appears at 0x0C with bits [11:0] read as 0. Its physical address appears at 0x10. An event with a zero type vector is ignored.
- R6: In `ST_HELD`, later events change none of the captured registers.
- R7: Offset 0x14 reads the requester: bits [3:0] hold the port, equal to ID[11:8]. Bits [6:4] hold the group, equal to (6 − ID[15:13]) modulo 8. Bits [31:16] hold the raw ID. Other bits read 0.
- R8: `irq_o` is the OR over all types of (captured type bit AND its enable). It follows enable writes in the same cycle the write lands.
- R9: Writing the clear bit returns the unit to `ST_IDLE` and zeroes the captured registers. If an event arrives in the same cycle as the clear, the clear wins and the event is dropped.
- R10: Offset 0x18 holds the protect buffer address. Bits [6:0] always read 0 and the upper bits keep what was written.
- R11: `redir_o` is high exactly while a fault is held, and `redir_addr_o` equals the protect buffer address.
- R12: A read request returns `rd_data_o` with `rd_valid_o` one cycle later. Unmapped offsets, and addresses whose two low bits are nonzero, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write byte address |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read request |
| rd_addr_i | input | 5 | Register read byte address |
| rd_valid_o | output | 1 | Read data valid, one cycle after request |
| rd_data_o | output | 32 | Read data |
| evt_valid_i | input | 1 | Fault event strobe |
| evt_type_i | input | 8 | Fault type vector |
| evt_va_i | input | 32 | Faulting virtual address |
| evt_pa_i | input | 32 | Offending physical address |
| evt_id_i | input | 16 | Requester identifier |
| irq_o | output | 1 | Fault interrupt |
| redir_o | output | 1 | Redirect faulting traffic |
| redir_addr_o | output | 32 | Protect buffer address |
| coh_en_o | output | 1 | Coherency enable |
| prot_sel_o | output | 2 | Protect select field |

## Verification
A write or fault event presented before a rising edge takes effect at that edge. `irq_o`, `redir_o`, `coh_en_o` and `prot_sel_o` are combinational from the registers, so they are due right after the edge. A read answers one edge after its request. The bench drives stimulus on falling edges and checks direct outputs at the next falling edge. Reads push their expected word into a scoreboard queue, and a monitor pops it on the falling edge where `rd_valid_o` is high.

// File: rtl/fcap_pkg.sv
package fcap_pkg;

    // Capture state machine
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } fcap_state_e;

    // Register word indices (byte offset / 4)
    localparam logic [2:0] IDX_CTRL  = 3'd0;
    localparam logic [2:0] IDX_INTC  = 3'd1;
    localparam logic [2:0] IDX_FSTAT = 3'd2;
    localparam logic [2:0] IDX_FVA   = 3'd3;
    localparam logic [2:0] IDX_FPA   = 3'd4;
    localparam logic [2:0] IDX_FSRC  = 3'd5;
    localparam logic [2:0] IDX_PROT  = 3'd6;

    // Field positions that software depends on
    localparam int CLR_BIT     = 12;
    localparam int COH_BIT     = 8;
    localparam int SEL_LSB     = 5;
    localparam int GROUP_BASE  = 6;

endpackage

// File: rtl/fcap_regs.sv
module fcap_regs
    import fcap_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NTYPE    = 8,
    parameter int ALIGN_LG = 7,
    parameter int IDX_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              coh_en_o,
    output logic [1:0]        prot_sel_o,
    output logic [NTYPE-1:0]  type_en_o,
    output logic              clr_o,
    output logic [DATA_W-1:0] prot_addr_o
);

    logic                         coh_q;
    logic [1:0]                   sel_q;
    logic [NTYPE-1:0]             en_q;
    logic [DATA_W-ALIGN_LG-1:0]   prot_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coh_q     <= 1'b0;
            sel_q     <= 2'b00;
            en_q      <= '0;
            prot_hi_q <= '0;
        end else if (wr_hit_i) begin
            unique case (wr_idx_i)
                IDX_CTRL: begin
                    coh_q <= wr_data_i[COH_BIT];
                    sel_q <= wr_data_i[SEL_LSB +: 2];
                end
                IDX_INTC: en_q      <= wr_data_i[NTYPE-1:0];
                IDX_PROT: prot_hi_q <= wr_data_i[DATA_W-1:ALIGN_LG];
                default: ;
            endcase
        end
    end

    // Clear strobe: lives for the write cycle only, never stored
    assign clr_o       = wr_hit_i && (wr_idx_i == IDX_INTC) && wr_data_i[CLR_BIT];
    assign coh_en_o    = coh_q;
    assign prot_sel_o  = sel_q;
    assign type_en_o   = en_q;
    assign prot_addr_o = {prot_hi_q, {ALIGN_LG{1'b0}}};

endmodule

// File: rtl/fcap_capture.sv
module fcap_capture
    import fcap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NTYPE  = 8,
    parameter int ID_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid_i,
    input  logic [NTYPE-1:0]  evt_type_i,
    input  logic [DATA_W-1:0] evt_va_i,
    input  logic [DATA_W-1:0] evt_pa_i,
    input  logic [ID_W-1:0]   evt_id_i,
    input  logic              clr_i,
    output logic              held_o,
    output logic [NTYPE-1:0]  stat_o,
    output logic [DATA_W-1:0] va_o,
    output logic [DATA_W-1:0] pa_o,
    output logic [ID_W-1:0]   id_o
);

    fcap_state_e st_q, st_nx;
    logic        take;
    logic        evt_hit;

    assign evt_hit = evt_valid_i && (|evt_type_i);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // Next state and outputs
    always_comb begin
        st_nx  = st_q;
        take   = 1'b0;
        held_o = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (!clr_i && evt_hit) begin   // CAPTURE
                    st_nx = ST_HELD;
                    take  = 1'b1;
                end
            end
            ST_HELD: begin
                held_o = 1'b1;
                if (clr_i) st_nx = ST_IDLE;    // RELEASE
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // Captured record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_o <= '0;
            va_o   <= '0;
            pa_o   <= '0;
            id_o   <= '0;
        end else if (clr_i) begin
            stat_o <= '0;
            va_o   <= '0;
            pa_o   <= '0;
            id_o   <= '0;
        end else if (take) begin
            stat_o <= evt_type_i;
            va_o   <= evt_va_i;
            pa_o   <= evt_pa_i;
            id_o   <= evt_id_i;
        end
    end

    AST_CAPTURE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && evt_hit && !clr_i) |=> (held_o && stat_o != '0)); // R5

    AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HELD && !clr_i) |=> ($stable(va_o) && $stable(stat_o) && $stable(pa_o))); // R6

    AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!held_o && stat_o == '0)); // R9

endmodule

// File: rtl/fcap_srcdec.sv
module fcap_srcdec
    import fcap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ID_W   = 16
) (
    input  logic [ID_W-1:0]   id_i,
    output logic [DATA_W-1:0] src_word_o
);

    logic [2:0] grp;
    logic [3:0] port;

    assign grp  = 3'(GROUP_BASE) - id_i[15:13];
    assign port = id_i[11:8];

    always_comb begin
        src_word_o                    = '0;
        src_word_o[3:0]               = port;
        src_word_o[6:4]               = grp;
        src_word_o[DATA_W-1 -: ID_W]  = id_i;
    end

endmodule

// File: rtl/fcap_unit.sv
module fcap_unit
    import fcap_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5,
    parameter int NTYPE    = 8,
    parameter int ID_W     = 16,
    parameter int PAGE_LG  = 12,
    parameter int ALIGN_LG = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              evt_valid_i,
    input  logic [NTYPE-1:0]  evt_type_i,
    input  logic [DATA_W-1:0] evt_va_i,
    input  logic [DATA_W-1:0] evt_pa_i,
    input  logic [ID_W-1:0]   evt_id_i,
    output logic              irq_o,
    output logic              redir_o,
    output logic [DATA_W-1:0] redir_addr_o,
    output logic              coh_en_o,
    output logic [1:0]        prot_sel_o
);

    localparam int IDX_W = ADDR_W - 2;

    logic              wr_hit;
    logic              rd_ok;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [NTYPE-1:0]  type_en, stat;
    logic              clr, held;
    logic [DATA_W-1:0] prot_addr, cap_va, cap_pa, src_word, rd_mux;
    logic [ID_W-1:0]   cap_id;

    assign wr_idx = wr_addr_i[ADDR_W-1:2];
    assign rd_idx = rd_addr_i[ADDR_W-1:2];
    assign wr_hit = wr_en_i && (wr_addr_i[1:0] == 2'b00);
    assign rd_ok  = (rd_addr_i[1:0] == 2'b00);

    fcap_regs #(
        .DATA_W(DATA_W), .NTYPE(NTYPE), .ALIGN_LG(ALIGN_LG), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_hit_i(wr_hit), .wr_idx_i(wr_idx), .wr_data_i(wr_data_i),
        .coh_en_o(coh_en_o), .prot_sel_o(prot_sel_o), .type_en_o(type_en),
        .clr_o(clr), .prot_addr_o(prot_addr)
    );

    fcap_capture #(
        .DATA_W(DATA_W), .NTYPE(NTYPE), .ID_W(ID_W)
    ) u_cap (
        .clk(clk), .rst_n(rst_n),
        .evt_valid_i(evt_valid_i), .evt_type_i(evt_type_i),
        .evt_va_i(evt_va_i), .evt_pa_i(evt_pa_i), .evt_id_i(evt_id_i),
        .clr_i(clr), .held_o(held), .stat_o(stat),
        .va_o(cap_va), .pa_o(cap_pa), .id_o(cap_id)
    );

    fcap_srcdec #(
        .DATA_W(DATA_W), .ID_W(ID_W)
    ) u_src (
        .id_i(cap_id), .src_word_o(src_word)
    );

    assign irq_o        = |(stat & type_en);
    assign redir_o      = held;
    assign redir_addr_o = prot_addr;

    always_comb begin
        rd_mux = '0;
        if (rd_ok) begin
            case (rd_idx)
                IDX_CTRL: begin
                    rd_mux[COH_BIT]        = coh_en_o;
                    rd_mux[SEL_LSB +: 2]   = prot_sel_o;
                end
                IDX_INTC:  rd_mux[NTYPE-1:0] = type_en;
                IDX_FSTAT: rd_mux[NTYPE-1:0] = stat;
                IDX_FVA:   rd_mux = {cap_va[DATA_W-1:PAGE_LG], {PAGE_LG{1'b0}}};
                IDX_FPA:   rd_mux = cap_pa;
                IDX_FSRC:  rd_mux = src_word;
                IDX_PROT:  rd_mux = prot_addr;
                default:   rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_en_i;
            if (rd_en_i) rd_data_o <= rd_mux;
        end
    end

    AST_IRQ_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> redir_o); // R8

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o); // R12

endmodule

// File: tb/sim_fcap_unit.sv
`timescale 1ns/1ps
module sim_fcap_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        evt_valid = 1'b0;
    logic [7:0]  evt_type = '0;
    logic [31:0] evt_va = '0, evt_pa = '0;
    logic [15:0] evt_id = '0;
    logic        irq, redir, coh_en;
    logic [31:0] redir_addr;
    logic [1:0]  prot_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    fcap_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data),
        .evt_valid_i(evt_valid), .evt_type_i(evt_type),
        .evt_va_i(evt_va), .evt_pa_i(evt_pa), .evt_id_i(evt_id),
        .irq_o(irq), .redir_o(redir), .redir_addr_o(redir_addr),
        .coh_en_o(coh_en), .prot_sel_o(prot_sel)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every returned read
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12: unexpected read data actual 0x%08h expected none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic fault(input logic [7:0] t, input logic [31:0] va,
                         input logic [31:0] pa, input logic [15:0] id, input bit with_clr);
        @(negedge clk);
        evt_valid = 1'b1; evt_type = t; evt_va = va; evt_pa = pa; evt_id = id;
        if (with_clr) begin wr_en = 1'b1; wr_addr = 5'h04; wr_data = 32'h0000_1080; end
        @(negedge clk);
        evt_valid = 1'b0; wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 redir", {31'b0, redir}, 0);
        check("R1 coh_en", {31'b0, coh_en}, 0);
        reg_rd(5'h00, 0, "R1 ctrl");
        reg_rd(5'h04, 0, "R1 intc");
        reg_rd(5'h08, 0, "R1 fstat");
        reg_rd(5'h18, 0, "R1 prot");

        // R2 control word
        reg_wr(5'h00, 32'hFFFF_FFFF);
        check("R2 coh_en", {31'b0, coh_en}, 1);
        check("R2 prot_sel", {30'b0, prot_sel}, 3);
        reg_rd(5'h00, 32'h0000_0160, "R2 ctrl readback");

        // R3 enables, R4 clear reads 0
        reg_wr(5'h04, 32'hFFFF_FFFF);
        reg_rd(5'h04, 32'h0000_00FF, "R3 R4 intc readback");

        // R10 protect address alignment
        reg_wr(5'h18, 32'h1234_5FFF);
        reg_rd(5'h18, 32'h1234_5F80, "R10 prot");

        // R5 capture with enables off
        reg_wr(5'h04, 32'h0);
        fault(8'h01, 32'hABCD_E123, 32'h8000_0044, 16'h4A00, 0);
        check("R8 irq disabled", {31'b0, irq}, 0);
        check("R11 redir", {31'b0, redir}, 1);
        check("R11 redir_addr", redir_addr, 32'h1234_5F80);
        reg_rd(5'h08, 32'h0000_0001, "R5 fstat");
        reg_rd(5'h0C, 32'hABCD_E000, "R5 fva");
        reg_rd(5'h10, 32'h8000_0044, "R5 fpa");
        reg_rd(5'h14, 32'h4A00_004A, "R7 fsrc");

        // R8 enable gating
        reg_wr(5'h04, 32'h01);
        check("R8 irq enabled", {31'b0, irq}, 1);
        reg_wr(5'h04, 32'h02);
        check("R8 irq other enable", {31'b0, irq}, 0);

        // R6 second fault ignored
        fault(8'h20, 32'h1111_1FFF, 32'h2222_0000, 16'h0100, 0);
        reg_rd(5'h08, 32'h0000_0001, "R6 fstat kept");
        reg_rd(5'h0C, 32'hABCD_E000, "R6 fva kept");

        // R9 clear
        reg_wr(5'h04, 32'h0000_1001);
        check("R9 irq", {31'b0, irq}, 0);
        check("R9 redir", {31'b0, redir}, 0);
        reg_rd(5'h08, 0, "R9 fstat zero");
        reg_rd(5'h04, 32'h0000_0001, "R4 intc after clear");

        // R7 group wraparound, R8 with matching enable
        reg_wr(5'h04, 32'h80);
        fault(8'h80, 32'h0000_5000, 32'h0000_0010, 16'hE300, 0);
        check("R8 irq type7", {31'b0, irq}, 1);
        reg_rd(5'h14, 32'hE300_0073, "R7 fsrc wrap");

        // R9 clear and event together: clear wins
        fault(8'h04, 32'h7777_7000, 32'h1, 16'h0, 1);
        check("R9 clear wins redir", {31'b0, redir}, 0);
        reg_rd(5'h08, 0, "R9 clear wins fstat");

        // R5 zero-type event ignored
        fault(8'h00, 32'h9999_9000, 32'h2, 16'h0, 0);
        check("R5 zero type redir", {31'b0, redir}, 0);
        reg_rd(5'h08, 0, "R5 zero type fstat");

        // R12 unmapped and misaligned
        reg_rd(5'h1C, 0, "R12 unmapped");
        reg_rd(5'h19, 0, "R12 misaligned");

        @(negedge clk);
        @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R12: actual %0d pending reads expected 0", exp_q.size());
        end
        done = 1;
        finish_run();
    end

endmodule